// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This block generates up to eight pulse-width-modulated outputs from one shared up-counter. A clock-enable source is chosen from three inputs and can be divided by a power of two. The counter runs from zero up to a programmable modulo value and then returns to zero. Each channel owns a compare value. In the plain mode a channel is active from the wrap until the counter reaches its compare value. Compare values of zero and at or above the modulo give the 0% and 100% cases.

Neighbouring channels can be joined into a pair. In that mode the even channel's value marks where the pulse begins and the odd channel's value marks where it ends, which gives a phase-shifted pulse on the even pin. A per-channel polarity bit selects an active-high or active-low pin. Software-style writes of the modulo and compare values go into shadow copies. The running period picks them up only at the next wrap, so a period is never cut short or stretched mid-flight.

Top module: `edge_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, every register is 0 and every pin is low; the counter stays stopped until a clock source is selected.
- R2: Control bits [4:3] select the count enable: 0 none (the counter holds its value), 1 `sys_tick_en`, 2 `fix_tick_en`, 3 `ext_tick_en`.
- R3: Control bits [2:0] hold a prescale code p. The counter advances once per 2^p selected enables, from 1 to 128. A write to the control register restarts the divider.
- R4: On each prescaled tick the counter adds one. On the tick where it equals the active modulo, it returns to 0 instead.
- R5: In plain mode, with a compare value c where 0 < c < modulo, the channel is active while the counter is below c and inactive from c up to the wrap.
- R6: In plain mode a compare value of 0 keeps the channel inactive for the whole period.
- R7: In plain mode a nonzero compare value at or above the active modulo keeps the channel active for the whole period.
- R8: A polarity bit of 0 makes the active level high and a bit of 1 makes it low (pin = active XOR polarity bit n).
- R9: Writing 1 to bit 8k of the pair register joins channels 2k and 2k+1. The even pin is then active while even value <= counter < odd value. The odd pin sits at its inactive level.
- R10: In a joined pair whose even value is not below its odd value, the even pin stays inactive for the whole period.
- R11: Modulo and compare writes go to shadow copies that become active on the next wrap. A write that lands on the same clock edge as a wrap waits for the following wrap. Polarity, pair and control writes act at once.
- R12: Register addresses: 0 control, 1 modulo (bits [15:0]), 2 polarity (bits [7:0]), 3 pair joins, 8+n compare value of channel n (bits [15:0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_tick_en | input | 1 | System count enable |
| fix_tick_en | input | 1 | Fixed-rate count enable |
| ext_tick_en | input | 1 | External count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pwm_out | output | 8 | Channel pins |
| cnt_o | output | 16 | Current counter value |

## Verification
A shadow write and a counter wrap can fall on the same clock edge. In that case the active register must take the old shadow value, and the new value must appear only one period later. The bench provokes this on purpose by waiting until the counter sits at the modulo and then issuing a compare write, so that the write edge is the wrap edge. It then checks the pin in the next period against the old value and in the period after that against the new one. The random phase repeats the situation at unplanned moments, and a cycle-accurate bench model of shadow and active copies judges every output cycle.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } clk_src_e;

    localparam int ADR_CTRL = 0;
    localparam int ADR_MOD  = 1;
    localparam int ADR_POL  = 2;
    localparam int ADR_PAIR = 3;
    localparam int ADR_CMP0 = 8;
    localparam int PAIR_BIT_STRIDE = 8;

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
    import pwmt_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  clk_src_e        src,
    input  logic [PS_W-1:0] ps,
    input  logic            sys_en,
    input  logic            fix_en,
    input  logic            ext_en,
    input  logic            restart,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t pre_d, pre_q;
    logic       sel_en;
    logic [DIV_W:0] full_mask;
    logic [DIV_W-1:0] mask;

    always_comb begin
        case (src)
            SRC_SYS: sel_en = sys_en;
            SRC_FIX: sel_en = fix_en;
            SRC_EXT: sel_en = ext_en;
            default: sel_en = 1'b0;
        endcase
        full_mask = ({{DIV_W{1'b0}}, 1'b1} << ps) - 1'b1;
        mask      = full_mask[DIV_W-1:0];
        tick      = sel_en && ((pre_q.div & mask) == mask);
        pre_d     = pre_q;
        if (restart) begin
            pre_d.div = '0;
        end else if (sel_en) begin
            pre_d.div = pre_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] mod_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        wrap  = tick && (cnt_q.cnt == mod_act);
        cnt_d = cnt_q;
        if (wrap)      cnt_d.cnt = '0;
        else if (tick) cnt_d.cnt = cnt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q.cnt;
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int PS_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       wrap,
    output clk_src_e                   src,
    output logic [PS_W-1:0]            ps,
    output logic [NCH-1:0]             pol,
    output logic [NCH/2-1:0]           pair_en,
    output logic [CNT_W-1:0]           mod_act,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_act,
    output logic                       ctrl_wr
);
    localparam int NPAIR   = NCH / 2;
    localparam int SRC_LSB = PS_W;

    typedef struct packed {
        clk_src_e                  src;
        logic [PS_W-1:0]           ps;
        logic [NCH-1:0]            pol;
        logic [NPAIR-1:0]          pair;
        logic [CNT_W-1:0]          mod_sh;
        logic [CNT_W-1:0]          mod_act;
        logic [NCH-1:0][CNT_W-1:0] cmp_sh;
        logic [NCH-1:0][CNT_W-1:0] cmp_act;
    } reg_st_t;

    reg_st_t reg_d, reg_q;

    always_comb begin
        reg_d   = reg_q;
        ctrl_wr = 1'b0;
        // Shadow copies move into the active set only at the wrap edge.
        if (wrap) begin
            reg_d.mod_act = reg_q.mod_sh;
            reg_d.cmp_act = reg_q.cmp_sh;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_CTRL)) begin
                reg_d.ps  = wr_data[PS_W-1:0];
                reg_d.src = clk_src_e'(wr_data[SRC_LSB+1:SRC_LSB]);
                ctrl_wr   = 1'b1;
            end
            if (wr_addr == ADDR_W'(ADR_MOD)) reg_d.mod_sh = wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_POL)) reg_d.pol    = wr_data[NCH-1:0];
            if (wr_addr == ADDR_W'(ADR_PAIR)) begin
                for (int k = 0; k < NPAIR; k++) begin
                    reg_d.pair[k] = wr_data[PAIR_BIT_STRIDE*k];
                end
            end
            for (int n = 0; n < NCH; n++) begin
                if (wr_addr == ADDR_W'(ADR_CMP0 + n)) reg_d.cmp_sh[n] = wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign src     = reg_q.src;
    assign ps      = reg_q.ps;
    assign pol     = reg_q.pol;
    assign pair_en = reg_q.pair;
    assign mod_act = reg_q.mod_act;
    assign cmp_act = reg_q.cmp_act;
endmodule

// File: rtl/pwmt_pair.sv
module pwmt_pair #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mod_act,
    input  logic [CNT_W-1:0] cmp_even,
    input  logic [CNT_W-1:0] cmp_odd,
    input  logic             joined,
    input  logic [1:0]       pol,
    output logic [1:0]       pin
);
    logic [1:0] act;
    logic       even_plain, odd_plain, even_joined;

    always_comb begin
        even_plain  = (cmp_even != '0) && ((cmp_even >= mod_act) || (cnt < cmp_even));
        odd_plain   = (cmp_odd  != '0) && ((cmp_odd  >= mod_act) || (cnt < cmp_odd));
        even_joined = (cmp_even < cmp_odd) && (cnt >= cmp_even) && (cnt < cmp_odd);
        act[0] = joined ? even_joined : even_plain;
        act[1] = joined ? 1'b0        : odd_plain;
        pin    = act ^ pol;
    end
endmodule

// File: rtl/edge_pwm_timer.sv
module edge_pwm_timer
    import pwmt_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_tick_en,
    input  logic              fix_tick_en,
    input  logic              ext_tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int NPAIR = NCH / 2;

    clk_src_e                  cfg_src;
    logic [PS_W-1:0]           cfg_ps;
    logic [NCH-1:0]            cfg_pol;
    logic [NPAIR-1:0]          cfg_pair;
    logic [CNT_W-1:0]          mod_act;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic                      ctrl_wr;
    logic                      tick;
    logic                      wrap;
    logic [CNT_W-1:0]          cnt;

    pwmt_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wrap(wrap), .src(cfg_src), .ps(cfg_ps), .pol(cfg_pol), .pair_en(cfg_pair),
        .mod_act(mod_act), .cmp_act(cmp_act), .ctrl_wr(ctrl_wr)
    );

    pwmt_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .src(cfg_src), .ps(cfg_ps),
        .sys_en(sys_tick_en), .fix_en(fix_tick_en), .ext_en(ext_tick_en),
        .restart(ctrl_wr), .tick(tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mod_act(mod_act), .cnt(cnt), .wrap(wrap)
    );

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        pwmt_pair #(.CNT_W(CNT_W)) u_pair (
            .cnt(cnt), .mod_act(mod_act),
            .cmp_even(cmp_act[2*k]), .cmp_odd(cmp_act[2*k+1]),
            .joined(cfg_pair[k]), .pol(cfg_pol[2*k+1:2*k]),
            .pin(pwm_out[2*k+1:2*k])
        );
    end

    assign cnt_o = cnt;
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                src,
    input logic                      tick,
    input logic                      wrap,
    input logic [CNT_W-1:0]          cnt,
    input logic [CNT_W-1:0]          mod_act,
    input logic [NCH/2-1:0]          pair_en,
    input logic [NCH-1:0]            pol,
    input logic [NCH-1:0][CNT_W-1:0] cmp_act,
    input logic [NCH-1:0]            pwm_out
);
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd0) |=> $stable(cnt));

    a_r4_within_modulo: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mod_act);

    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != mod_act) |=> (cnt == $past(cnt) + 1'b1));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    a_r11_mod_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mod_act));

    for (genvar k = 0; k < NCH/2; k++) begin : g_pairchk
        a_r9_odd_idle: assert property (@(posedge clk) disable iff (!rst_n)
            pair_en[k] |-> (pwm_out[2*k+1] == pol[2*k+1]));
        a_r10_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_en[k] && cmp_act[2*k] >= cmp_act[2*k+1]) |-> (pwm_out[2*k] == pol[2*k]));
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chchk
        a_r6_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_act[n] == '0 && !pair_en[n/2]) |-> (pwm_out[n] == pol[n]));
    end
endmodule

bind edge_pwm_timer pwmt_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src(cfg_src), .tick(tick), .wrap(wrap), .cnt(cnt),
    .mod_act(mod_act), .pair_en(cfg_pair), .pol(cfg_pol), .cmp_act(cmp_act),
    .pwm_out(pwm_out)
);

// File: tb/test_edge_pwm_timer.sv
module test_edge_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_en = 1'b1, fix_en = 1'b0, ext_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pwm_out;
    logic [15:0] cnt_o;

    edge_pwm_timer i_edge_pwm_timer (
        .clk(clk), .rst_n(rst_n), .sys_tick_en(sys_en), .fix_tick_en(fix_en),
        .ext_tick_en(ext_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .cnt_o(cnt_o)
    );

    always #2 clk = ~clk;

    // fixed-rate enable: high for one edge out of every four
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 fix_en = 1'b1;
            @(posedge clk);
            #1 fix_en = 1'b0;
        end
    end

    int n_chk = 0, n_fail = 0;
    int m_src = 0, m_ps = 0;
    logic [15:0] s_mod = '0, a_mod = '0, prev_cnt = '0;
    logic [15:0] s_cmp [8];
    logic [15:0] a_cmp [8];
    logic [7:0]  m_pol = '0;
    logic [3:0]  m_pair = '0;
    logic        pend = 1'b0;
    logic [3:0]  p_addr = '0;
    logic [31:0] p_data = '0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic chan_act(int n, logic [15:0] c);
        if (m_pair[n/2]) begin
            if (n % 2 != 0) return 1'b0;
            return (a_cmp[n] < a_cmp[n+1]) && (c >= a_cmp[n]) && (c < a_cmp[n+1]);
        end
        return (a_cmp[n] != 0) && ((a_cmp[n] >= a_mod) || (c < a_cmp[n]));
    endfunction

    function automatic string chan_tag(int n);
        if (m_pair[n/2]) begin
            if (n % 2 == 0 && a_cmp[n] >= a_cmp[n+1]) return "R10";
            return "R9";
        end
        if (m_pol[n]) return "R8";
        if (a_cmp[n] == 0) return "R6";
        if (a_cmp[n] >= a_mod) return "R7";
        return "R5";
    endfunction

    task automatic apply_pending();
        if (p_addr == 4'd0) begin
            m_ps  = int'(p_data[2:0]);
            m_src = int'(p_data[4:3]);
        end else if (p_addr == 4'd1) s_mod = p_data[15:0];
        else if (p_addr == 4'd2) m_pol = p_data[7:0];
        else if (p_addr == 4'd3) m_pair = {p_data[24], p_data[16], p_data[8], p_data[0]};
        else if (p_addr >= 4'd8) s_cmp[p_addr - 4'd8] = p_data[15:0];
    endtask

    task automatic step();
        logic running;
        logic [15:0] exp_c;
        logic [7:0]  exp_o;
        @(posedge clk);
        #1;
        running = (m_src == 1 && m_ps == 0);
        if (running) begin
            exp_c = (prev_cnt == a_mod) ? 16'd0 : prev_cnt + 16'd1;
            chk(cnt_o == exp_c, "R4 counter", int'(cnt_o), int'(exp_c));
            if (prev_cnt == a_mod) begin
                a_mod = s_mod;
                for (int i = 0; i < 8; i++) a_cmp[i] = s_cmp[i];
            end
        end
        if (pend) apply_pending();
        pend = 1'b0;
        for (int i = 0; i < 8; i++) exp_o[i] = chan_act(i, cnt_o) ^ m_pol[i];
        chk(pwm_out == exp_o, "pins", int'(pwm_out), int'(exp_o));
        if (pwm_out != exp_o) begin
            for (int i = 0; i < 8; i++)
                if (pwm_out[i] != exp_o[i])
                    $display("  channel %0d mismatch under %s", i, chan_tag(i));
        end
        prev_cnt = cnt_o;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        pend = 1'b1; p_addr = a; p_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic run_to(input logic [15:0] v);
        for (int k = 0; k < 400; k++) begin
            step();
            if (cnt_o == v) break;
        end
    endtask

    task automatic gap(output int g);
        logic [15:0] base;
        g = 0;
        base = cnt_o;
        for (int k = 0; k < 400 && cnt_o == base; k++) step();
        base = cnt_o;
        for (int k = 0; k < 400 && cnt_o == base; k++) begin
            step();
            g++;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int g;
        logic [15:0] held;
        logic [15:0] md;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin s_cmp[i] = '0; a_cmp[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(cnt_o == 0, "R1 counter", int'(cnt_o), 0);
        chk(pwm_out == 0, "R1 pins", int'(pwm_out), 0);
        for (int i = 0; i < 10; i++) step();
        chk(cnt_o == 0, "R1 stopped without source", int'(cnt_o), 0);

        // directed setup: R5..R10 via the model, R12 via address decode
        wr(4'd1, 32'd9);
        wr(4'd8, 32'd3);  wr(4'd9, 32'd0);  wr(4'd10, 32'd9); wr(4'd11, 32'd12);
        wr(4'd12, 32'd2); wr(4'd13, 32'd6); wr(4'd14, 32'd7); wr(4'd15, 32'd4);
        wr(4'd2, 32'h18);
        wr(4'd3, 32'h0101_0000);
        wr(4'd0, 32'h8);
        for (int i = 0; i < 40; i++) begin
            step();
            chk(pwm_out[2] == 1'b1, "R12 compare 2 at address 10 full duty", int'(pwm_out[2]), 1);
        end

        // R11: write in mid-period waits for the wrap
        run_to(16'd2);
        wr(4'd8, 32'd7);
        run_to(16'd4);
        chk(pwm_out[0] == 1'b0, "R11 old compare kept", int'(pwm_out[0]), 0);
        run_to(16'd4);
        chk(pwm_out[0] == 1'b1, "R11 new compare at wrap", int'(pwm_out[0]), 1);
        // R11: write on the wrap edge itself
        run_to(16'd9);
        wr(4'd8, 32'd2);
        run_to(16'd5);
        chk(pwm_out[0] == 1'b1, "R11 write on wrap edge deferred", int'(pwm_out[0]), 1);
        run_to(16'd5);
        chk(pwm_out[0] == 1'b0, "R11 write on wrap edge applied", int'(pwm_out[0]), 0);

        // random configurations checked cycle by cycle
        for (int it = 0; it < 30; it++) begin
            md = 16'(1 + $urandom % 40);
            wr(4'd1, 32'(md));
            for (int c = 0; c < 8; c++) wr(4'(8 + c), $urandom % (32'(md) + 4));
            wr(4'd2, $urandom & 32'hFF);
            wr(4'd3, $urandom & 32'h0101_0101);
            for (int s = 0; s < 2 * (int'(md) + 1) + 6; s++) step();
        end

        // R3: prescaler
        wr(4'd1, 32'd200);
        run_to(16'd0);
        wr(4'd0, 32'h8 | 32'd3);
        gap(g);
        chk(g == 8, "R3 divide by 8", g, 8);
        wr(4'd0, 32'h8 | 32'd7);
        gap(g);
        chk(g == 128, "R3 divide by 128", g, 128);

        // R2: source select
        wr(4'd0, 32'h10);
        gap(g);
        chk(g == 4, "R2 fixed enable rate", g, 4);
        wr(4'd0, 32'h18);
        held = cnt_o;
        for (int i = 0; i < 10; i++) step();
        chk(cnt_o == held, "R2 external idle holds", int'(cnt_o), int'(held));
        ext_en = 1'b1;
        step();
        ext_en = 1'b0;
        chk(cnt_o == held + 16'd1, "R2 external pulse counts", int'(cnt_o), int'(held) + 1);
        wr(4'd0, 32'h0);
        held = cnt_o;
        for (int i = 0; i < 20; i++) step();
        chk(cnt_o == held, "R2 no source holds counter", int'(cnt_o), int'(held));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule